// File: doc/BRIEF.md
# TLB Miss Refill Walker

This block runs the hardware side of a TLB miss. When the lookup logic reports that a virtual address found no matching entry, the walker builds the virtual address of the page-table entry from the page-table base register, has that address translated through the TLB lookup port as a plain ring-0 data read (this translation never starts a walk of its own), reads the 32-bit entry from memory, and writes a new entry into one of the four refill ways. The way to overwrite is picked round-robin.

The new entry carries a 4 KB page frame, a 4-bit attribute field and an ASID. The ASID is the byte of the ring-ASID register that the entry's ring field selects. A successful refill also writes the miss address into the exception virtual-address register. A failed walk changes nothing and reports the original miss back to the requester. The walker handles one miss at a time: it shows busy while working and gives a one-cycle done pulse at the end. After a successful pulse the requester repeats its lookup, and that lookup now hits.

Top module: `refill_walker`

## Requirements
- R1: While the walker requests a translation, `xlat_vaddr` equals `(ptbase | (miss_vaddr >> 10))` with bits 1:0 forced to zero, and it stays stable until `xlat_resp_valid`.
- R2: When the translation comes back with `xlat_ok` low, no memory read is issued, no TLB write happens, and the walk ends with `done` high and `done_ok` low. When it succeeds, `mem_addr` equals the returned `xlat_paddr`.
- R3: A memory response with `mem_err` high ends the walk with `done` high, `done_ok` low, and no TLB write.
- R4: The installed entry takes its attribute from entry bits 3:0, its ring from bits 5:4, and its frame `tlbw_ppn` from entry bits 31:12, with the low 12 bits zero.
- R5: `tlbw_asid` is byte number `ring` of `ring_asid` (bits `8*ring+7 : 8*ring`).
- R6: A 2-bit refill counter resets to 0. It is incremented before each successful install, and its new value is the victim way, so refills after reset land in ways 1, 2, 3, 0, 1 and so on.
- R7: `tlbw_index` is `miss_vaddr[13:12]` (for the default of four entries per way), and `tlbw_vpn` is the miss address with bits 11:0 cleared.
- R8: `exc_vaddr` resets to 0. It takes the miss address on the clock edge that ends a successful install and does not change on a failed walk.
- R9: `busy` is high from the cycle after a miss is accepted until the cycle after `done`. A `miss_valid` that arrives while `busy` is high is ignored and does not start a walk.
- R10: `done` is a single-cycle pulse. `tlbw_valid` is high exactly when `done` and `done_ok` are both high, and `tlbw_is_data` repeats the side of the accepted miss.
- R11: A failed walk does not advance the refill counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | Miss request, accepted while idle |
| miss_vaddr | input | 32 | Virtual address that missed |
| miss_is_data | input | 1 | 1 for a data-side miss, 0 for instruction side |
| ptbase | input | 32 | Page-table base register |
| ring_asid | input | 32 | Four ASID bytes, byte n belongs to ring n |
| busy | output | 1 | Walk in progress |
| xlat_req | output | 1 | Translation request to the TLB lookup (ring-0 load, no walk) |
| xlat_vaddr | output | 32 | Entry virtual address to translate |
| xlat_resp_valid | input | 1 | Translation result valid |
| xlat_ok | input | 1 | Translation succeeded |
| xlat_paddr | input | 32 | Translated physical address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Physical address of the entry |
| mem_resp_valid | input | 1 | Read data valid |
| mem_err | input | 1 | Bus error on the read |
| mem_rdata | input | 32 | Page-table entry read |
| tlbw_valid | output | 1 | TLB write strobe |
| tlbw_is_data | output | 1 | Side of the TLB to write |
| tlbw_way | output | 2 | Victim refill way |
| tlbw_index | output | 2 | Entry index within the way |
| tlbw_vpn | output | 32 | Virtual page, low 12 bits zero |
| tlbw_ppn | output | 32 | Physical frame, low 12 bits zero |
| tlbw_asid | output | 8 | ASID for the entry |
| tlbw_attr | output | 4 | Attribute field |
| exc_vaddr | output | 32 | Exception virtual-address register |
| done | output | 1 | Walk finished (one cycle) |
| done_ok | output | 1 | Walk installed an entry |

## Verification
The checker watches every cycle for these rules: the translation address holds until it is answered, a memory read follows only a successful translation, a translation fault or bus error ends the walk without a write, victim ways step by one starting at way 1, the exception register follows each install, misses arriving while busy leave the captured address alone, and done lasts one cycle. Whether the computed addresses, the PPN, the attribute and the ring-selected ASID hold the right values can only be shown by the bench scenarios, which compare them with values computed independently. The same applies to the counter holding still across failed walks, and to a miss offered during a walk producing no second completion.

// File: rtl/refill_walk_pkg.sv
package refill_walk_pkg;

  typedef enum logic [2:0] {
    W_IDLE    = 3'd0,
    W_XLAT    = 3'd1,
    W_FETCH   = 3'd2,
    W_INSTALL = 3'd3,
    W_FAIL    = 3'd4
  } walk_state_t;

  localparam int unsigned PAGE_SHIFT = 12;
  localparam logic [31:0] PAGE_MASK  = ~((32'd1 << PAGE_SHIFT) - 32'd1);

  // Virtual address of the page-table entry covering va
  function automatic logic [31:0] pte_vaddr_of(input logic [31:0] base,
                                               input logic [31:0] va);
    return (base | (va >> 10)) & ~32'h3;
  endfunction

  function automatic logic [1:0] pte_ring(input logic [31:0] pte);
    return 2'(pte >> 4);
  endfunction

  function automatic logic [3:0] pte_attr(input logic [31:0] pte);
    return 4'(pte);
  endfunction

  function automatic logic [31:0] page_frame(input logic [31:0] x);
    return x & PAGE_MASK;
  endfunction

  function automatic logic [7:0] asid_for_ring(input logic [31:0] rasid,
                                               input logic [1:0]  ring);
    return 8'(rasid >> {ring, 3'b000});
  endfunction

endpackage

// File: rtl/refill_walk_ctrl.sv
module refill_walk_ctrl
  import refill_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        miss_valid,
  input  logic        miss_is_data,
  input  logic [31:0] miss_vaddr,
  input  logic [31:0] ptbase,
  input  logic        xlat_resp_valid,
  input  logic        xlat_ok,
  input  logic [31:0] xlat_paddr,
  input  logic        mem_resp_valid,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output walk_state_t state_q,
  output logic [31:0] va_q,
  output logic [31:0] pte_va_q,
  output logic [31:0] pa_q,
  output logic [31:0] pte_q,
  output logic        side_q,
  output logic        accept,
  output logic        install,
  output logic        fail
);

  walk_state_t state_d;

  assign accept  = (state_q == W_IDLE) && miss_valid;
  assign install = (state_q == W_INSTALL);
  assign fail    = (state_q == W_FAIL);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      W_IDLE:    if (miss_valid) state_d = W_XLAT;
      W_XLAT:    if (xlat_resp_valid) state_d = xlat_ok ? W_FETCH : W_FAIL;
      W_FETCH:   if (mem_resp_valid) state_d = mem_err ? W_FAIL : W_INSTALL;
      W_INSTALL: state_d = W_IDLE;
      W_FAIL:    state_d = W_IDLE;
      default:   state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= W_IDLE;
      va_q     <= '0;
      pte_va_q <= '0;
      pa_q     <= '0;
      pte_q    <= '0;
      side_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        va_q     <= miss_vaddr;
        side_q   <= miss_is_data;
        pte_va_q <= pte_vaddr_of(ptbase, miss_vaddr);
      end
      if (state_q == W_XLAT && xlat_resp_valid && xlat_ok) pa_q <= xlat_paddr;
      if (state_q == W_FETCH && mem_resp_valid && !mem_err) pte_q <= mem_rdata;
    end
  end

endmodule

// File: rtl/refill_victim_picker.sv
module refill_victim_picker #(
  parameter int unsigned WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [WAY_W-1:0] victim
);

  logic [WAY_W-1:0] cnt_q;

  // Pre-increment: the victim is the value the counter is about to take
  assign victim = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (advance) cnt_q <= victim;
  end

endmodule

// File: rtl/refill_entry_former.sv
module refill_entry_former
  import refill_walk_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic [31:0]      va,
  input  logic [31:0]      pte,
  input  logic [31:0]      rasid,
  output logic [31:0]      vpn,
  output logic [IDX_W-1:0] index,
  output logic [31:0]      ppn,
  output logic [7:0]       asid,
  output logic [3:0]       attr
);

  assign vpn   = page_frame(va);
  assign index = IDX_W'(va >> PAGE_SHIFT);
  assign ppn   = page_frame(pte);
  assign attr  = pte_attr(pte);
  assign asid  = asid_for_ring(rasid, pte_ring(pte));

endmodule

// File: rtl/refill_walker.sv
module refill_walker
  import refill_walk_pkg::*;
#(
  parameter int unsigned WAY_W = 2,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [31:0]      miss_vaddr,
  input  logic             miss_is_data,
  input  logic [31:0]      ptbase,
  input  logic [31:0]      ring_asid,
  output logic             busy,
  output logic             xlat_req,
  output logic [31:0]      xlat_vaddr,
  input  logic             xlat_resp_valid,
  input  logic             xlat_ok,
  input  logic [31:0]      xlat_paddr,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_resp_valid,
  input  logic             mem_err,
  input  logic [31:0]      mem_rdata,
  output logic             tlbw_valid,
  output logic             tlbw_is_data,
  output logic [WAY_W-1:0] tlbw_way,
  output logic [IDX_W-1:0] tlbw_index,
  output logic [31:0]      tlbw_vpn,
  output logic [31:0]      tlbw_ppn,
  output logic [7:0]       tlbw_asid,
  output logic [3:0]       tlbw_attr,
  output logic [31:0]      exc_vaddr,
  output logic             done,
  output logic             done_ok
);

  walk_state_t walk_state;
  logic [31:0] walk_va;
  logic [31:0] walk_pte;
  logic        walk_accept;
  logic        walk_install;
  logic        walk_fail;
  logic        walk_side;

  refill_walk_ctrl i_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .miss_valid      (miss_valid),
    .miss_is_data    (miss_is_data),
    .miss_vaddr      (miss_vaddr),
    .ptbase          (ptbase),
    .xlat_resp_valid (xlat_resp_valid),
    .xlat_ok         (xlat_ok),
    .xlat_paddr      (xlat_paddr),
    .mem_resp_valid  (mem_resp_valid),
    .mem_err         (mem_err),
    .mem_rdata       (mem_rdata),
    .state_q         (walk_state),
    .va_q            (walk_va),
    .pte_va_q        (xlat_vaddr),
    .pa_q            (mem_addr),
    .pte_q           (walk_pte),
    .side_q          (walk_side),
    .accept          (walk_accept),
    .install         (walk_install),
    .fail            (walk_fail)
  );

  refill_victim_picker #(.WAY_W(WAY_W)) i_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (walk_install),
    .victim  (tlbw_way)
  );

  refill_entry_former #(.IDX_W(IDX_W)) i_former (
    .va    (walk_va),
    .pte   (walk_pte),
    .rasid (ring_asid),
    .vpn   (tlbw_vpn),
    .index (tlbw_index),
    .ppn   (tlbw_ppn),
    .asid  (tlbw_asid),
    .attr  (tlbw_attr)
  );

  assign busy         = (walk_state != W_IDLE);
  assign xlat_req     = (walk_state == W_XLAT);
  assign mem_req      = (walk_state == W_FETCH);
  assign tlbw_valid   = walk_install;
  assign tlbw_is_data = walk_side;
  assign done         = walk_install | walk_fail;
  assign done_ok      = walk_install;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            exc_vaddr <= '0;
    else if (walk_install) exc_vaddr <= walk_va;
  end

endmodule

// File: rtl/refill_walker_checks.sv
module refill_walker_checks #(
  parameter int unsigned WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic             busy,
  input logic             xlat_req,
  input logic [31:0]      xlat_vaddr,
  input logic             xlat_resp_valid,
  input logic             xlat_ok,
  input logic             mem_req,
  input logic             mem_resp_valid,
  input logic             mem_err,
  input logic             tlbw_valid,
  input logic [WAY_W-1:0] tlbw_way,
  input logic [31:0]      tlbw_vpn,
  input logic [31:0]      exc_vaddr,
  input logic [31:0]      walk_va,
  input logic             done,
  input logic             done_ok
);

  logic [WAY_W-1:0] last_way;
  logic             seen_install;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_way     <= '0;
      seen_install <= 1'b0;
    end else if (tlbw_valid) begin
      last_way     <= tlbw_way;
      seen_install <= 1'b1;
    end
  end

  p_hold_xlat_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req && !xlat_resp_valid) |=> $stable(xlat_vaddr));

  p_fetch_needs_xlat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(xlat_resp_valid && xlat_ok));

  p_xlat_fault_fails_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req && xlat_resp_valid && !xlat_ok) |=> (done && !done_ok && !tlbw_valid));

  p_buserr_fails_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_resp_valid && mem_err) |=> (done && !done_ok && !tlbw_valid));

  p_first_way_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbw_valid && !seen_install) |-> (tlbw_way == WAY_W'(1)));

  p_way_rotates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbw_valid && seen_install) |-> (tlbw_way == WAY_W'(last_way + 1'b1)));

  p_excv_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tlbw_valid |=> (exc_vaddr[31:12] == $past(tlbw_vpn[31:12])));

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && miss_valid) |=> $stable(walk_va));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_write_iff_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tlbw_valid == (done && done_ok));

endmodule

bind refill_walker refill_walker_checks #(.WAY_W(WAY_W)) i_checks (
  .clk             (clk),
  .rst_n           (rst_n),
  .miss_valid      (miss_valid),
  .busy            (busy),
  .xlat_req        (xlat_req),
  .xlat_vaddr      (xlat_vaddr),
  .xlat_resp_valid (xlat_resp_valid),
  .xlat_ok         (xlat_ok),
  .mem_req         (mem_req),
  .mem_resp_valid  (mem_resp_valid),
  .mem_err         (mem_err),
  .tlbw_valid      (tlbw_valid),
  .tlbw_way        (tlbw_way),
  .tlbw_vpn        (tlbw_vpn),
  .exc_vaddr       (exc_vaddr),
  .walk_va         (walk_va),
  .done            (done),
  .done_ok         (done_ok)
);

// File: tb/test_refill_walker.sv
module test_refill_walker;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RASID = 32'h5A3C_1F07;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_vaddr = '0;
  logic        miss_is_data = 1'b0;
  logic [31:0] ptbase = '0;
  logic [31:0] ring_asid = RASID;
  logic        busy, xlat_req, mem_req;
  logic [31:0] xlat_vaddr, mem_addr;
  logic        xlat_resp_valid = 1'b0;
  logic        xlat_ok = 1'b0;
  logic [31:0] xlat_paddr = '0;
  logic        mem_resp_valid = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tlbw_valid, tlbw_is_data;
  logic [1:0]  tlbw_way, tlbw_index;
  logic [31:0] tlbw_vpn, tlbw_ppn, exc_vaddr;
  logic [7:0]  tlbw_asid;
  logic [3:0]  tlbw_attr;
  logic        done, done_ok;

  refill_walker i_refill_walker (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        ok;
    logic        side;
    logic [1:0]  way;
    logic [1:0]  idx;
    logic [31:0] vpn;
    logic [31:0] ppn;
    logic [7:0]  asid;
    logic [3:0]  attr;
    logic [31:0] xaddr;
    logic [31:0] paddr;
    logic        xfault;
    logic [31:0] excv;
  } exp_t;

  exp_t sb_q[$];

  int checks = 0;
  int errors = 0;
  int processed = 0;
  int mem_reads = 0;
  logic [1:0]  model_cnt = 2'd0;
  logic [31:0] model_excv = 32'd0;
  logic [31:0] seen_xaddr = '0;
  logic [31:0] seen_maddr = '0;

  // responder knobs
  logic        k_xfault = 1'b0;
  logic        k_merr = 1'b0;
  logic [31:0] k_pa = '0;
  logic [31:0] k_pte = '0;
  int          k_lat = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // translation responder
  initial begin
    int wait_x = 0;
    forever begin
      @(negedge clk);
      if (xlat_resp_valid) xlat_resp_valid = 1'b0;
      else if (xlat_req) begin
        if (wait_x >= k_lat) begin
          seen_xaddr      = xlat_vaddr;
          xlat_ok         = !k_xfault;
          xlat_paddr      = k_pa;
          xlat_resp_valid = 1'b1;
          wait_x          = 0;
        end else wait_x++;
      end
    end
  end

  // memory responder
  initial begin
    int wait_m = 0;
    forever begin
      @(negedge clk);
      if (mem_resp_valid) mem_resp_valid = 1'b0;
      else if (mem_req) begin
        if (wait_m >= k_lat) begin
          seen_maddr     = mem_addr;
          mem_err        = k_merr;
          mem_rdata      = k_pte;
          mem_resp_valid = 1'b1;
          mem_reads++;
          wait_m         = 0;
        end else wait_m++;
      end
    end
  end

  // monitor: pops expectations when the walker finishes
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected completion: actual done=1 expected none");
        end else begin
          e = sb_q.pop_front();
          chk("R10", "done_ok", 32'(done_ok), 32'(e.ok));
          chk("R10", "tlbw_valid", 32'(tlbw_valid), 32'(e.ok));
          if (e.xfault) chk("R2", "no memory read", 32'(mem_reads), 32'd0);
          else          chk("R1", "xlat_vaddr", seen_xaddr, e.xaddr);
          if (e.ok) begin
            chk("R2", "mem_addr", seen_maddr, e.paddr);
            chk("R6", "way", 32'(tlbw_way), 32'(e.way));
            chk("R7", "index", 32'(tlbw_index), 32'(e.idx));
            chk("R7", "vpn", tlbw_vpn, e.vpn);
            chk("R4", "ppn", tlbw_ppn, e.ppn);
            chk("R4", "attr", 32'(tlbw_attr), 32'(e.attr));
            chk("R5", "asid", 32'(tlbw_asid), 32'(e.asid));
            chk("R10", "side", 32'(tlbw_is_data), 32'(e.side));
          end
          @(negedge clk);
          chk("R10", "done pulse", 32'(done), 32'd0);
          chk("R8", "exc_vaddr", exc_vaddr, e.excv);
          chk("R9", "busy after done", 32'(busy), 32'd0);
        end
        processed++;
      end
    end
  end

  task automatic run_walk(input logic [31:0] va, input logic side,
                          input logic [31:0] pt, input logic [31:0] pte,
                          input logic [31:0] pa, input logic xf,
                          input logic me, input int lat, input logic intrude);
    exp_t e;
    int target;
    @(negedge clk);
    while (busy) @(negedge clk);
    ptbase = pt; k_pte = pte; k_pa = pa; k_xfault = xf; k_merr = me; k_lat = lat;
    mem_reads = 0;
    e.ok     = !xf && !me;
    e.xfault = xf;
    e.side   = side;
    e.xaddr  = {(pt[31:2] | {10'd0, va[31:12]}), 2'b00};
    e.paddr  = pa;
    e.idx    = va[13:12];
    e.vpn    = {va[31:12], 12'h000};
    e.ppn    = {pte[31:12], 12'h000};
    e.attr   = pte[3:0];
    case (pte[5:4])
      2'd0: e.asid = RASID[7:0];
      2'd1: e.asid = RASID[15:8];
      2'd2: e.asid = RASID[23:16];
      default: e.asid = RASID[31:24];
    endcase
    if (e.ok) begin
      model_cnt  = model_cnt + 2'd1;
      model_excv = va;
    end
    e.way  = model_cnt;
    e.excv = model_excv;
    sb_q.push_back(e);
    target = processed + 1;
    miss_vaddr = va; miss_is_data = side; miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    if (intrude) begin
      miss_vaddr = ~va; miss_is_data = ~side; miss_valid = 1'b1;
      repeat (2) @(negedge clk);
      miss_valid = 1'b0;
    end
    wait (processed == target);
    if (intrude) begin
      repeat (6) @(negedge clk);
      chk("R9", "no walk from ignored miss", 32'(busy), 32'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset busy", 32'(busy), 32'd0);
    chk("R10", "reset done", 32'(done), 32'd0);
    chk("R10", "reset tlbw_valid", 32'(tlbw_valid), 32'd0);
    chk("R8", "reset exc_vaddr", exc_vaddr, 32'd0);
    chk("R1", "reset xlat_req", 32'(xlat_req), 32'd0);
    chk("R2", "reset mem_req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    // R6 first refill lands in way 1; ring 2, attr 3
    run_walk(32'h1234_5678, 1'b1, 32'h8000_0000, 32'hABCD_E023, 32'h0010_0A00, 0, 0, 0, 0);
    // instruction side, ring 0, attr F, slow responders
    run_walk(32'h0040_3ABC, 1'b0, 32'hC000_0000, 32'h1111_100F, 32'h0020_0FF0, 0, 0, 2, 0);
    // ring 1 and ring 3
    run_walk(32'hFFFF_F123, 1'b1, 32'h4000_0000, 32'h7654_3FD9, 32'h0030_0004, 0, 0, 1, 0);
    run_walk(32'h0000_2000, 1'b1, 32'h0000_0000, 32'h0000_1035, 32'h0000_0000, 0, 0, 0, 0);
    // R2 translation fault, R3 bus error, R11 counter holds
    run_walk(32'h8765_4321, 1'b1, 32'h8000_0000, 32'h1234_5037, 32'h0040_0000, 1, 0, 1, 0);
    run_walk(32'h2468_ACE0, 1'b0, 32'h8000_0000, 32'h1234_5037, 32'h0050_0000, 0, 1, 0, 0);
    // R11: next success continues the rotation after the failures (way 1 again)
    run_walk(32'h1357_9BDF, 1'b1, 32'hA000_0000, 32'hFEDC_B01E, 32'h0060_0008, 0, 0, 0, 0);
    // R9: miss offered during a walk is ignored
    run_walk(32'h0ABC_D000, 1'b0, 32'h9000_0000, 32'h5555_5022, 32'h0070_000C, 0, 0, 3, 1);
    run_walk(32'h3000_3000, 1'b1, 32'h9000_0000, 32'h0BAD_F011, 32'h0080_0010, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R9", "queue drained", 32'(sb_q.size()), 32'd0);
    summary();
    $finish;
  end

endmodule